// File: doc/BRIEF.md
# Round-Robin Request Spreader

This block accepts memory requests from one upstream requester and deals them out over `NUM_LANES` downstream link lanes in a fixed rotation. All the lanes reach the same memory, so the block does no address decoding. It sends each offered request to the lane under a rotation pointer. The pointer moves on to the next lane for every offered request, whether or not that request is taken.

Each lane has an occupancy timer. A request whose lane is occupied is turned away at once, and nothing appears downstream. A request on a free lane is presented to that lane. If the lane declines it, the request is refused upstream and the lane is blocked for the following cycle. If the lane takes it, the lane stays occupied while the payload streams.

For accepted requests that expect an answer, the block remembers the upstream port by transaction tag so that the response can be routed back. It also keeps a packet count and a byte count per lane. It holds one address window, learned only from announcements made by lane 0.

Top module: `rr_load_spreader`

## Requirements
- R1: After reset all lanes are free, the rotation pointer is 0 (the first offered request goes to lane 0), every packet and byte counter reads 0, the route table is empty and `map_known` is 0.
- R2: In every cycle with `up_valid` high, the request is presented to lane `ptr` only, as `dn_valid` bit `ptr`. The pointer then advances to `(ptr+1) mod NUM_LANES`, whether the request was accepted or refused. Without `up_valid` the pointer holds.
- R3: If the selected lane is occupied, `up_ready` is 0 and every `dn_valid` bit is 0 in that cycle.
- R4: If the selected lane is free but its `dn_ready` bit is 0, `up_ready` is 0 and that lane refuses any request offered to it in the next cycle.
- R5: When a request is accepted (`up_ready` high), its lane is occupied for exactly ceil(B / `LANE_BYTES_PER_CYCLE`) cycles after the accepting edge. B is `up_size` when `up_has_data` is 1 and 0 otherwise. With the default of 16, a 48-byte request occupies the lane for 3 cycles, a 49-byte or 64-byte request for 4 cycles, and a request without data for none.
- R6: `dn_cmd`, `dn_addr`, `dn_size`, `dn_has_data`, `dn_needs_rsp` and `dn_tag` mirror the upstream fields combinationally. `dn_delay` equals `FRONT_LAT + FWD_LAT` (3 by default).
- R7: An accepted request with `up_needs_rsp` 1 and `up_rsp_elsewhere` 0 creates a route entry for `up_tag`. Refused requests and requests answered elsewhere create none. `rsp_hit` and `rsp_src` report the entry for `rsp_tag` at all times. A cycle with `rsp_valid` 1 removes that entry at the clock edge.
- R8: Each accepted request adds 1 to its lane's packet counter and B (as in R5) to its lane's byte counter. Lane i occupies bits `[i*CNT_W +: CNT_W]` of `pkt_cnt` and of `byte_cnt`.
- R9: A range announcement (`rng_valid` 1) loads `map_lo`/`map_hi` and sets `map_known` only when `rng_lane` is 0. Announcements from other lanes leave all three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request offered |
| up_ready | output | 1 | Request accepted this cycle |
| up_cmd | input | CMD_W | Command code |
| up_addr | input | ADDR_W | Request address |
| up_size | input | SIZE_W | Payload size in bytes |
| up_has_data | input | 1 | Request carries payload |
| up_needs_rsp | input | 1 | Request expects a response |
| up_rsp_elsewhere | input | 1 | Another agent will answer |
| up_tag | input | TAG_W | Transaction tag |
| dn_valid | output | NUM_LANES | Per-lane request present |
| dn_ready | input | NUM_LANES | Per-lane accept |
| dn_cmd | output | CMD_W | Forwarded command |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_size | output | SIZE_W | Forwarded size |
| dn_has_data | output | 1 | Forwarded payload flag |
| dn_needs_rsp | output | 1 | Forwarded response flag |
| dn_tag | output | TAG_W | Forwarded tag |
| dn_delay | output | DELAY_W | Header delay in cycles |
| rsp_valid | input | 1 | Response returned, retire its entry |
| rsp_tag | input | TAG_W | Tag looked up / retired |
| rsp_hit | output | 1 | Route entry present for rsp_tag |
| rsp_src | output | SRC_W | Upstream port stored for rsp_tag |
| rng_valid | input | 1 | Address range announcement |
| rng_lane | input | PTR_W | Announcing lane |
| rng_lo | input | ADDR_W | Announced lower bound |
| rng_hi | input | ADDR_W | Announced upper bound |
| map_known | output | 1 | Window learned |
| map_lo | output | ADDR_W | Window lower bound |
| map_hi | output | ADDR_W | Window upper bound |
| pkt_cnt | output | NUM_LANES*CNT_W | Per-lane packet counters |
| byte_cnt | output | NUM_LANES*CNT_W | Per-lane byte counters |

## Verification
The route-table checks assume two things about the inputs. First, the requester never reuses a tag whose entry is still live. Second, a response is never signalled for a tag with no entry, and never in the same cycle that a new entry for that tag is made. The stimulus gives each response-expecting request a fresh tag and retires it only after its entry has been observed. Table contents are probed with `rsp_valid` low, which reads without retiring. The range checks assume `rng_lane` is below `NUM_LANES`, and the bench announces only on lanes 0 to 2.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

   // cycles a lane stays occupied for a payload of the given byte count
   function automatic int unsigned beats_for(input int unsigned nbytes,
                                             input int unsigned per_cycle);
      return (nbytes + per_cycle - 1) / per_cycle;
   endfunction

   // upstream port identifier stored in the route table (single requester)
   localparam int unsigned UPSTREAM_ID = 0;

endpackage

// File: rtl/rrd_rotator.sv
module rrd_rotator #(
   parameter int NUM_LANES = 4,
   parameter int PTR_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_LANES - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/rrd_lane_timer.sv
module rrd_lane_timer #(
   parameter int BEAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              stall,
   input  logic [BEAT_W-1:0] beats,
   output logic              busy
);
   logic [BEAT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (take)           left_q <= beats;
      else if (stall)          left_q <= BEAT_W'(1);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   // R4: a downstream refusal blocks the lane in the next cycle
   a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stall && !take |=> busy);
   // R5: a payload-bearing accept occupies the lane
   a_r5_take_occupies: assert property (@(posedge clk) disable iff (!rst_n)
      take && (beats != '0) |=> busy);
   // R5: an accept without payload leaves the lane free
   a_r5_empty_free: assert property (@(posedge clk) disable iff (!rst_n)
      take && (beats == '0) |=> !busy);
endmodule

// File: rtl/rrd_route_table.sv
module rrd_route_table #(
   parameter int TAG_W = 4,
   parameter int SRC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [TAG_W-1:0] set_tag,
   input  logic [SRC_W-1:0] set_src,
   input  logic             clr_en,
   input  logic [TAG_W-1:0] look_tag,
   output logic             look_hit,
   output logic [SRC_W-1:0] look_src
);
   localparam int DEPTH = 1 << TAG_W;

   logic [DEPTH-1:0] live_q;
   logic [SRC_W-1:0] src_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else begin
         if (clr_en) live_q[look_tag] <= 1'b0;
         if (set_en) live_q[set_tag]  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (set_en) src_q[set_tag] <= set_src;
   end

   assign look_hit = live_q[look_tag];
   assign look_src = src_q[look_tag];

   // R7: a tag is never recorded twice while its entry is live
   a_r7_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !live_q[set_tag]);
   // R7: a response must find its entry
   a_r7_rsp_known: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> live_q[look_tag]);
endmodule

// File: rtl/rr_load_spreader.sv
module rr_load_spreader #(
   parameter int NUM_LANES            = 4,
   parameter int LANE_BYTES_PER_CYCLE = 16,
   parameter int CMD_W                = 4,
   parameter int ADDR_W               = 32,
   parameter int SIZE_W               = 8,
   parameter int TAG_W                = 4,
   parameter int SRC_W                = 1,
   parameter int CNT_W                = 32,
   parameter int DELAY_W              = 8,
   parameter int FRONT_LAT            = 2,
   parameter int FWD_LAT              = 1,
   localparam int PTR_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       up_valid,
   output logic                       up_ready,
   input  logic [CMD_W-1:0]           up_cmd,
   input  logic [ADDR_W-1:0]          up_addr,
   input  logic [SIZE_W-1:0]          up_size,
   input  logic                       up_has_data,
   input  logic                       up_needs_rsp,
   input  logic                       up_rsp_elsewhere,
   input  logic [TAG_W-1:0]           up_tag,
   output logic [NUM_LANES-1:0]       dn_valid,
   input  logic [NUM_LANES-1:0]       dn_ready,
   output logic [CMD_W-1:0]           dn_cmd,
   output logic [ADDR_W-1:0]          dn_addr,
   output logic [SIZE_W-1:0]          dn_size,
   output logic                       dn_has_data,
   output logic                       dn_needs_rsp,
   output logic [TAG_W-1:0]           dn_tag,
   output logic [DELAY_W-1:0]         dn_delay,
   input  logic                       rsp_valid,
   input  logic [TAG_W-1:0]           rsp_tag,
   output logic                       rsp_hit,
   output logic [SRC_W-1:0]           rsp_src,
   input  logic                       rng_valid,
   input  logic [PTR_W-1:0]           rng_lane,
   input  logic [ADDR_W-1:0]          rng_lo,
   input  logic [ADDR_W-1:0]          rng_hi,
   output logic                       map_known,
   output logic [ADDR_W-1:0]          map_lo,
   output logic [ADDR_W-1:0]          map_hi,
   output logic [NUM_LANES*CNT_W-1:0] pkt_cnt,
   output logic [NUM_LANES*CNT_W-1:0] byte_cnt
);
   import rrd_pkg::*;

   localparam int MAX_BEATS = beats_for((1 << SIZE_W) - 1, LANE_BYTES_PER_CYCLE);
   localparam int BEAT_W    = (MAX_BEATS > 0) ? $clog2(MAX_BEATS + 1) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_LANES - 1);

   // elaboration-time parameter checks
   if (NUM_LANES < 1)            begin : g_bad_lanes $error("NUM_LANES must be at least 1"); end
   if (LANE_BYTES_PER_CYCLE < 1) begin : g_bad_rate  $error("LANE_BYTES_PER_CYCLE must be at least 1"); end
   if (TAG_W < 1 || TAG_W > 8)   begin : g_bad_tag   $error("TAG_W must lie in 1..8"); end
   if (FRONT_LAT + FWD_LAT >= (1 << DELAY_W)) begin : g_bad_dly $error("latency sum exceeds DELAY_W"); end

   logic [PTR_W-1:0]     ptr;
   logic [NUM_LANES-1:0] lane_busy;
   logic                 sel_busy, sel_ready, accept, refuse;
   logic [SIZE_W-1:0]    pay_bytes;
   logic [BEAT_W-1:0]    pay_beats;

   // rotation pointer advances on every offered request
   rrd_rotator #(.NUM_LANES(NUM_LANES), .PTR_W(PTR_W)) u_rot (
      .clk(clk), .rst_n(rst_n), .advance(up_valid), .ptr(ptr));

   always_comb begin
      sel_busy  = 1'b0;
      sel_ready = 1'b0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (ptr == PTR_W'(i)) begin
            sel_busy  = lane_busy[i];
            sel_ready = dn_ready[i];
         end
      end
   end

   assign accept    = up_valid && !sel_busy && sel_ready;
   assign refuse    = up_valid && !sel_busy && !sel_ready;
   assign up_ready  = accept;
   assign pay_bytes = up_has_data ? up_size : '0;
   assign pay_beats = BEAT_W'(beats_for(int'(pay_bytes), LANE_BYTES_PER_CYCLE));

   // shared forward buses
   assign dn_cmd       = up_cmd;
   assign dn_addr      = up_addr;
   assign dn_size      = up_size;
   assign dn_has_data  = up_has_data;
   assign dn_needs_rsp = up_needs_rsp;
   assign dn_tag       = up_tag;
   assign dn_delay     = DELAY_W'(FRONT_LAT + FWD_LAT);

   // per-lane occupancy and counters
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic             hit;
      logic [CNT_W-1:0] pkt_q, byte_q;

      assign hit         = (ptr == PTR_W'(g));
      assign dn_valid[g] = up_valid && hit && !lane_busy[g];

      rrd_lane_timer #(.BEAT_W(BEAT_W)) u_tmr (
         .clk(clk), .rst_n(rst_n),
         .take(accept && hit), .stall(refuse && hit),
         .beats(pay_beats), .busy(lane_busy[g]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pkt_q  <= '0;
            byte_q <= '0;
         end else if (accept && hit) begin
            pkt_q  <= pkt_q + 1'b1;
            byte_q <= byte_q + CNT_W'(pay_bytes);
         end
      end

      assign pkt_cnt[g*CNT_W +: CNT_W]  = pkt_q;
      assign byte_cnt[g*CNT_W +: CNT_W] = byte_q;
   end

   // response routing
   rrd_route_table #(.TAG_W(TAG_W), .SRC_W(SRC_W)) u_route (
      .clk(clk), .rst_n(rst_n),
      .set_en(accept && up_needs_rsp && !up_rsp_elsewhere),
      .set_tag(up_tag), .set_src(SRC_W'(UPSTREAM_ID)),
      .clr_en(rsp_valid), .look_tag(rsp_tag),
      .look_hit(rsp_hit), .look_src(rsp_src));

   // address window learned from lane 0 only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_known <= 1'b0;
         map_lo    <= '0;
         map_hi    <= '0;
      end else if (rng_valid && rng_lane == '0) begin
         map_known <= 1'b1;
         map_lo    <= rng_lo;
         map_hi    <= rng_hi;
      end
   end

   // R2: pointer steps once per offered request, wrapping at the last lane
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
   // R2: pointer holds when nothing is offered
   a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(ptr));
   // R2: at most one lane sees the request
   a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_valid));
   // R3: an occupied lane receives nothing and the request is refused
   a_r3_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && sel_busy |-> (dn_valid == '0) && !up_ready);
   // R9: other lanes' announcements do not move the window
   a_r9_range_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      rng_valid && (rng_lane != '0) |=> $stable(map_lo) && $stable(map_hi) && $stable(map_known));
endmodule

// File: tb/test_rr_load_spreader.sv
module test_rr_load_spreader;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        up_valid = 0, up_has_data = 0, up_needs_rsp = 0, up_rsp_elsewhere = 0;
   logic [3:0]  up_cmd = 0, up_tag = 0;
   logic [31:0] up_addr = 0;
   logic [7:0]  up_size = 0;
   logic [3:0]  dn_ready = 0;
   logic        rsp_valid = 0;
   logic [3:0]  rsp_tag = 0;
   logic        rng_valid = 0;
   logic [1:0]  rng_lane = 0;
   logic [31:0] rng_lo = 0, rng_hi = 0;

   logic        up_ready, dn_has_data, dn_needs_rsp, rsp_hit, map_known;
   logic [3:0]  dn_valid, dn_cmd, dn_tag;
   logic [31:0] dn_addr, map_lo, map_hi;
   logic [7:0]  dn_size, dn_delay;
   logic [0:0]  rsp_src;
   logic [127:0] pkt_cnt, byte_cnt;

   rr_load_spreader i_rr_load_spreader (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_cmd(up_cmd), .up_addr(up_addr),
      .up_size(up_size), .up_has_data(up_has_data), .up_needs_rsp(up_needs_rsp),
      .up_rsp_elsewhere(up_rsp_elsewhere), .up_tag(up_tag),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_cmd(dn_cmd), .dn_addr(dn_addr),
      .dn_size(dn_size), .dn_has_data(dn_has_data), .dn_needs_rsp(dn_needs_rsp),
      .dn_tag(dn_tag), .dn_delay(dn_delay),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit), .rsp_src(rsp_src),
      .rng_valid(rng_valid), .rng_lane(rng_lane), .rng_lo(rng_lo), .rng_hi(rng_hi),
      .map_known(map_known), .map_lo(map_lo), .map_hi(map_hi),
      .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt));

   // single-lane instance: makes the one-cycle refusal hold observable
   logic        s_up_valid = 0;
   logic [0:0]  s_dn_ready = 0;
   logic        s_up_ready, s_dn_has, s_dn_needs, s_rsp_hit, s_known;
   logic [0:0]  s_dn_valid, s_rsp_src;
   logic [3:0]  s_dn_cmd, s_dn_tag;
   logic [31:0] s_dn_addr, s_lo, s_hi, s_pkt, s_byte;
   logic [7:0]  s_dn_size, s_dn_delay;

   rr_load_spreader #(.NUM_LANES(1)) i_rr_load_spreader_one (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s_up_valid), .up_ready(s_up_ready), .up_cmd(4'd0), .up_addr(32'd0),
      .up_size(8'd0), .up_has_data(1'b0), .up_needs_rsp(1'b0),
      .up_rsp_elsewhere(1'b0), .up_tag(4'd0),
      .dn_valid(s_dn_valid), .dn_ready(s_dn_ready), .dn_cmd(s_dn_cmd), .dn_addr(s_dn_addr),
      .dn_size(s_dn_size), .dn_has_data(s_dn_has), .dn_needs_rsp(s_dn_needs),
      .dn_tag(s_dn_tag), .dn_delay(s_dn_delay),
      .rsp_valid(1'b0), .rsp_tag(4'd0), .rsp_hit(s_rsp_hit), .rsp_src(s_rsp_src),
      .rng_valid(1'b0), .rng_lane(1'b0), .rng_lo(32'd0), .rng_hi(32'd0),
      .map_known(s_known), .map_lo(s_lo), .map_hi(s_hi),
      .pkt_cnt(s_pkt), .byte_cnt(s_byte));

   int n_chk = 0, n_bad = 0;
   int ptr_m = 0;
   int busy_m [4] = '{0, 0, 0, 0};
   longint pkt_m [4] = '{0, 0, 0, 0};
   longint byte_m [4] = '{0, 0, 0, 0};
   bit route_m [16];

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic age();
      for (int l = 0; l < 4; l++) if (busy_m[l] > 0) busy_m[l]--;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         up_valid = 0;
         @(posedge clk);
         age();
      end
   endtask

   // offer one request and compare handshake and forwarded fields with the model
   task automatic offer(input int size, input bit has, input bit needs, input bit els,
                        input int tag, input logic [3:0] rdy);
      int lane;
      bit free, acc;
      logic [3:0] exp_dnv;
      @(negedge clk);
      up_valid = 1; up_size = 8'(size); up_has_data = has; up_needs_rsp = needs;
      up_rsp_elsewhere = els; up_tag = 4'(tag); up_cmd = 4'(tag) ^ 4'h5;
      up_addr = 32'h4000_0000 + 32'(size * 7) + 32'(tag); dn_ready = rdy;
      #1;
      lane = ptr_m;
      free = (busy_m[lane] == 0);
      acc = free && rdy[lane];
      exp_dnv = free ? 4'(1 << lane) : 4'b0;
      chk("R2 R3 lane select dn_valid", 64'(dn_valid), 64'(exp_dnv));
      chk("R3 R4 R5 up_ready", 64'(up_ready), 64'(acc));
      chk("R6 forwarded fields and delay",
          {dn_addr, dn_tag, dn_size, dn_cmd, dn_delay},
          {up_addr, 4'(tag), 8'(size), 4'(tag) ^ 4'h5, 8'd3});
      @(posedge clk);
      age();
      if (acc) begin
         busy_m[lane] = has ? (size + 15) / 16 : 0;
         pkt_m[lane]++;
         byte_m[lane] += has ? size : 0;
         if (needs && !els) route_m[tag] = 1;
      end else if (free) begin
         busy_m[lane] = 1;
      end
      ptr_m = (ptr_m + 1) % 4;
   endtask

   task automatic check_counters(input string what);
      @(negedge clk);
      up_valid = 0;
      #1;
      for (int l = 0; l < 4; l++) begin
         chk({what, " pkt_cnt"}, 64'(pkt_cnt[l*32 +: 32]), 64'(pkt_m[l]));
         chk({what, " byte_cnt"}, 64'(byte_cnt[l*32 +: 32]), 64'(byte_m[l]));
      end
      @(posedge clk);
      age();
   endtask

   task automatic probe(input int tag);
      @(negedge clk);
      up_valid = 0; rsp_valid = 0; rsp_tag = 4'(tag);
      #1;
      chk("R7 route entry present", 64'(rsp_hit), 64'(route_m[tag]));
      @(posedge clk);
      age();
   endtask

   task automatic respond(input int tag);
      @(negedge clk);
      up_valid = 0; rsp_valid = 1; rsp_tag = 4'(tag);
      #1;
      chk("R7 response finds entry and source", {62'd0, rsp_hit, rsp_src}, 64'b10);
      @(posedge clk);
      age();
      route_m[tag] = 0;
      @(negedge clk);
      rsp_valid = 0;
      @(posedge clk);
      age();
   endtask

   task automatic test_reset();
      @(negedge clk);
      #1;
      chk("R1 map_known after reset", 64'(map_known), 64'd0);
      chk("R1 up_ready idle", 64'(up_ready), 64'd0);
      rsp_tag = 4'd0;
      #1;
      chk("R1 route table empty", 64'(rsp_hit), 64'd0);
      check_counters("R1 reset");
   endtask

   task automatic test_rotation();
      // R2: six accepted no-data requests walk lanes 0,1,2,3,0,1
      for (int k = 0; k < 6; k++) offer(0, 0, 0, 0, 0, 4'hF);
   endtask

   task automatic test_refusal();
      // R4: lane refusal still consumes the slot; the next request goes on
      offer(16, 1, 0, 0, 0, 4'h0);
      offer(16, 1, 0, 0, 0, 4'hF);
      idle(6);
   endtask

   task automatic test_payload();
      // R5: 64 bytes -> 4 cycles, 48 -> 3, 49 -> 4, no data -> 0
      while (ptr_m != 0) offer(0, 0, 0, 0, 0, 4'hF);
      idle(4);
      offer(64, 1, 0, 0, 0, 4'hF);
      for (int k = 0; k < 3; k++) offer(0, 0, 0, 0, 0, 4'hF);
      offer(0, 0, 0, 0, 0, 4'hF);              // lane 0 still occupied: R3
      for (int k = 0; k < 3; k++) offer(0, 0, 0, 0, 0, 4'hF);
      offer(48, 1, 0, 0, 0, 4'hF);             // lane 0 free again
      for (int k = 0; k < 3; k++) offer(32, 1, 0, 0, 0, 4'hF);
      offer(49, 1, 0, 0, 0, 4'hF);             // lane 0 free after 3 cycles
      for (int k = 0; k < 3; k++) offer(0, 0, 0, 0, 0, 4'hF);
      offer(200, 0, 0, 0, 0, 4'hF);            // lane 0 still occupied (4 cycles)
      for (int k = 0; k < 3; k++) offer(0, 0, 0, 0, 0, 4'hF);
      offer(200, 0, 0, 0, 0, 4'hF);            // no-data request: 0 bytes counted
      offer(0, 0, 0, 0, 0, 4'hF);              // lane 1 free right after
      idle(6);
   endtask

   task automatic test_route();
      idle(5);
      offer(8, 1, 1, 0, 3, 4'hF);
      probe(3);
      offer(8, 1, 1, 1, 5, 4'hF);              // answered elsewhere: no entry
      probe(5);
      offer(8, 1, 1, 0, 6, 4'h0);              // refused: no entry
      probe(6);
      respond(3);
      probe(3);
      idle(3);
   endtask

   task automatic test_range();
      @(negedge clk);
      rng_valid = 1; rng_lane = 2'd2; rng_lo = 32'h1111_0000; rng_hi = 32'h1111_FFFF;
      @(negedge clk);
      rng_valid = 0;
      #1;
      chk("R9 non-zero lane ignored", {31'd0, map_known, map_lo}, 64'd0);
      rng_valid = 1; rng_lane = 2'd0; rng_lo = 32'h2000_0000; rng_hi = 32'h2FFF_FFFF;
      @(negedge clk);
      rng_valid = 1; rng_lane = 2'd1; rng_lo = 32'h3000_0000; rng_hi = 32'h3FFF_FFFF;
      #1;
      chk("R9 lane 0 window loaded", {31'd0, map_known, map_lo}, {31'd0, 1'b1, 32'h2000_0000});
      @(negedge clk);
      rng_valid = 0;
      #1;
      chk("R9 lane 1 ignored after load", {map_lo, map_hi}, {32'h2000_0000, 32'h2FFF_FFFF});
   endtask

   task automatic test_single_lane();
      @(negedge clk);
      s_up_valid = 1; s_dn_ready = 1'b0;
      #1;
      chk("R4 single lane refused downstream", {62'd0, s_dn_valid, s_up_ready}, 64'b10);
      @(negedge clk);
      s_dn_ready = 1'b1;
      #1;
      chk("R4 lane held one cycle after refusal", {62'd0, s_dn_valid, s_up_ready}, 64'b00);
      @(negedge clk);
      #1;
      chk("R4 lane free two cycles after refusal", {62'd0, s_dn_valid, s_up_ready}, 64'b11);
      @(negedge clk);
      s_up_valid = 0;
      #1;
      chk("R8 single lane packet count", 64'(s_pkt), 64'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      test_reset();
      test_rotation();
      test_refusal();
      test_payload();
      check_counters("R8 after traffic");
      test_route();
      check_counters("R8 after route traffic");
      test_range();
      test_single_lane();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule